// File: doc/BRIEF.md
# Data and Instruction Fault Status Capture

This block holds the diagnostic registers that a translation unit fills in when an access faults. When the data-side fault strobe is high on a clock edge, the block records three values. The first is the faulting virtual address. The second is a formatted page-table-entry address, built from a software-written base register and the faulting page number. The third is a packed status word that holds the instruction opcode, the destination register number and six fault flags. The instruction side has its own strobe. It records the faulting program counter into a tag register and builds a formatted address from its own base register.

A capture is dropped when the access was speculative, when it was a page-table-entry fetch, or when it was marked as not allowed to fault. The registers are never locked. Each later qualifying fault overwrites them, so software always sees the most recent one. The captured registers drive read ports directly, and each base register has a write port. Decoding the instruction and choosing between competing faults are the job of the requester.

Top module: `fault_status_capture`

## Requirements
- R1: After reset every captured register and both base registers read zero.
- R2: On a clock edge where `dflt_strobe` is high and no suppress input is high, `dflt_va` takes the value of `dflt_vaddr`.
- R3: The captured status word carries the opcode in bits 16:11, the destination register number in bits 10:6 and the flags in bits 5:0. The flag bits are: bit 0 write, bit 1 access violation, bit 2 fault-on-read, bit 3 fault-on-write, bit 4 translation miss, bit 5 bad virtual address.
- R4: The captured data formatted address equals the data base register ORed with (`dflt_vaddr` >> 13) << 3, truncated to the address width.
- R5: When `dflt_strobe` is high and any of `dflt_spec`, `dflt_pte_fetch` or `dflt_nofault` is high, none of the three data registers changes.
- R6: Registers are not locked. A later qualifying data fault overwrites all three data registers.
- R7: A base register write takes effect at its clock edge. A capture on that same edge uses the old base value, and later captures use the new one.
- R8: On a clock edge with `iflt_strobe` high and `iflt_spec` low, `iflt_tag` takes `iflt_pc` and `iflt_form` takes the instruction base ORed with (`iflt_pc` >> 13) << 3. With `iflt_spec` high, neither register changes.
- R9: With a strobe low, the registers on that side keep their values whatever the other fault inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dflt_strobe | input | 1 | Data fault strobe |
| dflt_vaddr | input | VA_W | Faulting data virtual address |
| dflt_opcode | input | 6 | Opcode of the faulting instruction |
| dflt_dreg | input | 5 | Destination register number |
| dflt_flags | input | 6 | Fault flags (layout in R3) |
| dflt_spec | input | 1 | Access is speculative; suppress capture |
| dflt_pte_fetch | input | 1 | Access is a page-table-entry fetch; suppress capture |
| dflt_nofault | input | 1 | Access marked no-fault; suppress capture |
| iflt_strobe | input | 1 | Instruction fault strobe |
| iflt_pc | input | VA_W | Faulting program counter |
| iflt_spec | input | 1 | Fetch is speculative; suppress capture |
| dbase_we | input | 1 | Data base register write enable |
| dbase_wdata | input | VA_W | Data base register write value |
| ibase_we | input | 1 | Instruction base register write enable |
| ibase_wdata | input | VA_W | Instruction base register write value |
| dflt_va | output | VA_W | Captured data fault address |
| dflt_form | output | VA_W | Captured data formatted page-table address |
| dflt_stat | output | 17 | Captured data status word |
| iflt_tag | output | VA_W | Captured instruction fault PC |
| iflt_form | output | VA_W | Captured instruction formatted page-table address |

## Verification
The assertions assume that the strobes and suppress inputs are clean, defined levels sampled at each rising edge, and that a base write and a capture may share an edge. The bench drives every input on the falling edge and drops the strobes right after the capturing edge. It mixes suppressed and qualifying faults, idle cycles with changing fault inputs, and same-edge base writes, so each assertion condition is actually reached.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int FLG_W  = 6;
    localparam int STAT_W = OPC_W + REG_W + FLG_W;

    // Last field is bit 0 of the packed vector.
    typedef struct packed {
        logic bad_va;
        logic tlb_miss;
        logic fault_on_wr;
        logic fault_on_rd;
        logic acc_viol;
        logic is_write;
    } fsc_flags_t;
endpackage

// File: rtl/fsc_addr_former.sv
module fsc_addr_former #(
    parameter int VA_W       = 43,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] form
);
    localparam int VPN_W = VA_W - PAGE_SHIFT;

    logic [VPN_W-1:0] vpn;
    logic [VA_W-1:0]  vpn_wide;

    always_comb begin
        vpn      = vaddr[VA_W-1:PAGE_SHIFT];
        vpn_wide = {{PAGE_SHIFT{1'b0}}, vpn};
        form     = base | (vpn_wide << PTE_SHIFT);
    end
endmodule

// File: rtl/fsc_status_packer.sv
module fsc_status_packer
    import fsc_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [REG_W-1:0]  dreg,
    input  fsc_flags_t        flags,
    output logic [STAT_W-1:0] stat
);
    always_comb begin
        stat = {opcode, dreg, flags};
    end
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
    import fsc_pkg::*;
#(
    parameter int VA_W       = 43,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dflt_strobe,
    input  logic [VA_W-1:0]   dflt_vaddr,
    input  logic [OPC_W-1:0]  dflt_opcode,
    input  logic [REG_W-1:0]  dflt_dreg,
    input  logic [FLG_W-1:0]  dflt_flags,
    input  logic              dflt_spec,
    input  logic              dflt_pte_fetch,
    input  logic              dflt_nofault,
    input  logic              iflt_strobe,
    input  logic [VA_W-1:0]   iflt_pc,
    input  logic              iflt_spec,
    input  logic              dbase_we,
    input  logic [VA_W-1:0]   dbase_wdata,
    input  logic              ibase_we,
    input  logic [VA_W-1:0]   ibase_wdata,
    output logic [VA_W-1:0]   dflt_va,
    output logic [VA_W-1:0]   dflt_form,
    output logic [STAT_W-1:0] dflt_stat,
    output logic [VA_W-1:0]   iflt_tag,
    output logic [VA_W-1:0]   iflt_form
);
    localparam int N_SIDE = 2;  // 0: data, 1: instruction

    typedef struct packed {
        logic [VA_W-1:0]   dva;
        logic [VA_W-1:0]   dform;
        logic [STAT_W-1:0] dstat;
        logic [VA_W-1:0]   dbase;
        logic [VA_W-1:0]   itag;
        logic [VA_W-1:0]   iform;
        logic [VA_W-1:0]   ibase;
    } state_t;

    state_t state_d, state_q;

    logic [VA_W-1:0]   side_base [N_SIDE];
    logic [VA_W-1:0]   side_addr [N_SIDE];
    logic [VA_W-1:0]   side_form [N_SIDE];
    logic [STAT_W-1:0] stat_new;
    logic              dcap, icap;

    always_comb begin
        side_base[0] = state_q.dbase;
        side_addr[0] = dflt_vaddr;
        side_base[1] = state_q.ibase;
        side_addr[1] = iflt_pc;
    end

    for (genvar g = 0; g < N_SIDE; g++) begin : g_form
        fsc_addr_former #(
            .VA_W      (VA_W),
            .PAGE_SHIFT(PAGE_SHIFT),
            .PTE_SHIFT (PTE_SHIFT)
        ) u_former (
            .base (side_base[g]),
            .vaddr(side_addr[g]),
            .form (side_form[g])
        );
    end

    fsc_status_packer u_packer (
        .opcode(dflt_opcode),
        .dreg  (dflt_dreg),
        .flags (fsc_flags_t'(dflt_flags)),
        .stat  (stat_new)
    );

    always_comb begin
        dcap    = dflt_strobe && !(dflt_spec || dflt_pte_fetch || dflt_nofault);
        icap    = iflt_strobe && !iflt_spec;
        state_d = state_q;
        if (dcap) begin
            state_d.dva   = dflt_vaddr;
            state_d.dform = side_form[0];
            state_d.dstat = stat_new;
        end
        if (icap) begin
            state_d.itag  = iflt_pc;
            state_d.iform = side_form[1];
        end
        if (dbase_we) state_d.dbase = dbase_wdata;
        if (ibase_we) state_d.ibase = ibase_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dflt_va   = state_q.dva;
    assign dflt_form = state_q.dform;
    assign dflt_stat = state_q.dstat;
    assign iflt_tag  = state_q.itag;
    assign iflt_form = state_q.iform;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int VA_W = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dflt_strobe,
    input logic [VA_W-1:0]   dflt_vaddr,
    input logic [5:0]        dflt_opcode,
    input logic              dflt_spec,
    input logic              dflt_pte_fetch,
    input logic              dflt_nofault,
    input logic              iflt_strobe,
    input logic [VA_W-1:0]   iflt_pc,
    input logic              iflt_spec,
    input logic              dbase_we,
    input logic [VA_W-1:0]   dbase_wdata,
    input logic [VA_W-1:0]   dbase_now,
    input logic [VA_W-1:0]   dflt_va,
    input logic [VA_W-1:0]   dflt_form,
    input logic [16:0]       dflt_stat,
    input logic [VA_W-1:0]   iflt_tag,
    input logic [VA_W-1:0]   iflt_form
);
    logic sup;
    assign sup = dflt_spec || dflt_pte_fetch || dflt_nofault;

    assert_capture_va_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_strobe && !sup |=> dflt_va == $past(dflt_vaddr));

    assert_stat_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_strobe && !sup |=> dflt_stat[16:11] == $past(dflt_opcode));

    assert_form_base_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_strobe && !sup |=> dflt_form[2:0] == $past(dbase_now[2:0]));

    assert_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_strobe && sup |=> $stable(dflt_va) && $stable(dflt_form) && $stable(dflt_stat));

    assert_base_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbase_we |=> dbase_now == $past(dbase_wdata));

    assert_itag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iflt_strobe && !iflt_spec |=> iflt_tag == $past(iflt_pc));

    assert_ispec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iflt_strobe && iflt_spec |=> $stable(iflt_tag) && $stable(iflt_form));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dflt_strobe |=> $stable(dflt_va) && $stable(dflt_stat) && $stable(dflt_form));
endmodule

bind fault_status_capture fsc_checker #(.VA_W(VA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dflt_strobe   (dflt_strobe),
    .dflt_vaddr    (dflt_vaddr),
    .dflt_opcode   (dflt_opcode),
    .dflt_spec     (dflt_spec),
    .dflt_pte_fetch(dflt_pte_fetch),
    .dflt_nofault  (dflt_nofault),
    .iflt_strobe   (iflt_strobe),
    .iflt_pc       (iflt_pc),
    .iflt_spec     (iflt_spec),
    .dbase_we      (dbase_we),
    .dbase_wdata   (dbase_wdata),
    .dbase_now     (side_base[0]),
    .dflt_va       (dflt_va),
    .dflt_form     (dflt_form),
    .dflt_stat     (dflt_stat),
    .iflt_tag      (iflt_tag),
    .iflt_form     (iflt_form)
);

// File: tb/fault_status_capture_tb.sv
module fault_status_capture_tb;
    localparam int VA_W = 43;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dflt_strobe = 0, dflt_spec = 0, dflt_pte_fetch = 0, dflt_nofault = 0;
    logic [VA_W-1:0] dflt_vaddr = '0;
    logic [5:0]      dflt_opcode = '0;
    logic [4:0]      dflt_dreg = '0;
    logic [5:0]      dflt_flags = '0;
    logic            iflt_strobe = 0, iflt_spec = 0;
    logic [VA_W-1:0] iflt_pc = '0;
    logic            dbase_we = 0, ibase_we = 0;
    logic [VA_W-1:0] dbase_wdata = '0, ibase_wdata = '0;
    logic [VA_W-1:0] dflt_va, dflt_form, iflt_tag, iflt_form;
    logic [16:0]     dflt_stat;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    fault_status_capture u_dut (.*);

    typedef struct packed {
        logic            spec;
        logic            pte;
        logic            nf;
        logic [5:0]      op;
        logic [4:0]      rd;
        logic [5:0]      fl;
        logic [VA_W-1:0] va;
    } vec_t;

    // Rows with a suppress bit set must leave the registers unchanged (R5).
    localparam vec_t VT [8] = '{
        '{1'b0, 1'b0, 1'b0, 6'h29, 5'd3,  6'b000001, 43'h000_1234_5678},
        '{1'b0, 1'b0, 1'b0, 6'h3F, 5'd31, 6'b010000, 43'h7FF_FFFF_FFFF},
        '{1'b1, 1'b0, 1'b0, 6'h01, 5'd1,  6'b000010, 43'h111_1111_1111},
        '{1'b0, 1'b0, 1'b0, 6'h00, 5'd0,  6'b100011, 43'h000_0000_2000},
        '{1'b0, 1'b1, 1'b0, 6'h02, 5'd2,  6'b000100, 43'h222_2222_2222},
        '{1'b0, 1'b0, 1'b1, 6'h03, 5'd4,  6'b001000, 43'h333_3333_3333},
        '{1'b0, 1'b0, 1'b0, 6'h15, 5'd17, 6'b001101, 43'h5A5_A5A5_A5A5},
        '{1'b1, 1'b1, 1'b1, 6'h3E, 5'd30, 6'b111111, 43'h444_4444_4444}
    };

    logic [VA_W-1:0] exp_va = '0, exp_form = '0, exp_dbase = '0;
    logic [VA_W-1:0] exp_itag = '0, exp_iform = '0, exp_ibase = '0;
    logic [16:0]     exp_stat = '0;

    function automatic logic [VA_W-1:0] fmt(input logic [VA_W-1:0] b, input logic [VA_W-1:0] a);
        logic [VA_W-1:0] v;
        v = a >> 13;
        return b | (v << 3);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_data(input string req);
        chk({req, " va"},   64'(dflt_va),   64'(exp_va));
        chk({req, " form"}, 64'(dflt_form), 64'(exp_form));
        chk({req, " stat"}, 64'(dflt_stat), 64'(exp_stat));
    endtask

    task automatic dfault(input vec_t v, input logic wr_base, input logic [VA_W-1:0] nb);
        @(negedge clk);
        dflt_strobe = 1; dflt_spec = v.spec; dflt_pte_fetch = v.pte; dflt_nofault = v.nf;
        dflt_opcode = v.op; dflt_dreg = v.rd; dflt_flags = v.fl; dflt_vaddr = v.va;
        dbase_we = wr_base; dbase_wdata = nb;
        @(posedge clk);
        @(negedge clk);
        dflt_strobe = 0; dbase_we = 0;
        if (!(v.spec || v.pte || v.nf)) begin
            exp_va   = v.va;
            exp_form = fmt(exp_dbase, v.va);
            exp_stat = {v.op, v.rd, v.fl};
        end
        if (wr_base) exp_dbase = nb;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check_data("R1");
        chk("R1 itag",  64'(iflt_tag),  0);
        chk("R1 iform", 64'(iflt_form), 0);

        // R1: base reset to zero shows in the first formatted address
        dfault('{1'b0, 1'b0, 1'b0, 6'h0A, 5'd5, 6'b000001, 43'h000_00FF_E000}, 1'b0, '0);
        check_data("R1 R4 zero base");

        // program data base
        @(negedge clk);
        dbase_we = 1; dbase_wdata = 43'h100_0000_0005;
        @(negedge clk);
        dbase_we = 0; exp_dbase = 43'h100_0000_0005;

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            dfault(VT[i], 1'b0, '0);
            check_data((VT[i].spec || VT[i].pte || VT[i].nf) ? "R5" : "R2 R3 R4 R6");
        end

        // R9: strobe low, other inputs toggle
        @(negedge clk);
        dflt_vaddr = 43'h6666_6666_666; dflt_opcode = 6'h11; dflt_flags = 6'h3F;
        repeat (2) @(negedge clk);
        check_data("R9");

        // R7: base write on the capture edge uses old base, then new base
        dfault('{1'b0, 1'b0, 1'b0, 6'h07, 5'd9, 6'b000010, 43'h012_3456_7000}, 1'b1, 43'h200_0000_0002);
        check_data("R7 old base");
        dfault('{1'b0, 1'b0, 1'b0, 6'h08, 5'd10, 6'b000100, 43'h012_3456_7000}, 1'b0, '0);
        check_data("R7 new base");

        // R8: instruction side
        @(negedge clk);
        ibase_we = 1; ibase_wdata = 43'h300_0000_0001;
        @(negedge clk);
        ibase_we = 0; exp_ibase = 43'h300_0000_0001;
        iflt_strobe = 1; iflt_pc = 43'h0AB_CDEF_0124;
        @(negedge clk);
        iflt_strobe = 0;
        exp_itag = 43'h0AB_CDEF_0124; exp_iform = fmt(exp_ibase, exp_itag);
        chk("R8 itag",  64'(iflt_tag),  64'(exp_itag));
        chk("R8 iform", 64'(iflt_form), 64'(exp_iform));
        check_data("R9 data idle during ifault");
        iflt_strobe = 1; iflt_spec = 1; iflt_pc = 43'h777_0000_0000;
        @(negedge clk);
        iflt_strobe = 0; iflt_spec = 0;
        @(negedge clk);
        chk("R8 spec itag",  64'(iflt_tag),  64'(exp_itag));
        chk("R8 spec iform", 64'(iflt_form), 64'(exp_iform));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule